// File: doc/BRIEF.md
# Backup Domain Control Register

This block is the control register for a battery-backed clock domain. It is reached through a byte-wide write/read port with a small address space. It holds three domain settings: an oscillator enable, a fault-monitor enable and a counter clock select. It also holds an access-enable bit and issues a self-clearing domain reset. Its outputs drive the crystal oscillator enable, the oscillator monitor enable and the clock select of the domain counter. It also gives the rest of the domain a level that says whether register access is open.

The two enables can only be set. Only a domain reset or a loss of domain power clears them. The clock select is frozen once the oscillator runs. A reset request is dropped when the same write also sets an enable. The access-enable bit lives in the main power domain and clears on every main reset. The domain settings survive a main reset. A status register shows the synchronized oscillator ready flag, which is subject to the access gate. It also shows three power flags, which are always visible. The intended bring-up order is: start the oscillator, wait for ready, enable the monitor, then set up the counter.

Top module: `bkup_ctl_reg`

## Requirements
- R1: Control bits 7:5 always read as 0, and writing ones to them changes no output and no readable bit.
- R2: Writing 1 to control bit 3 sets the oscillator enable (`osc_en_o`). Writing 0 leaves it unchanged. Only a domain reset clears it.
- R3: Writing 1 to control bit 2 sets the monitor enable (`mon_en_o`). Writing 0 leaves it unchanged. Only a domain reset clears it.
- R4: Control bit 4 is the clock select (`clk_sel_o`): 0 selects the 1 Hz output and 1 selects the 1.024 kHz output. A write to this bit is ignored while the oscillator enable is already set.
- R5: Writing 1 to control bit 0 is a domain reset. On the clock edge that takes the write, it clears the oscillator enable, the monitor enable, the clock select and the ready flag. `dom_rst_o` is high for exactly the cycle after that edge, and bit 0 reads as 0.
- R6: A write with bit 0 set is not a reset when the same write has bit 3 or bit 2 set. The enables in that write take effect, and `dom_rst_o` stays low.
- R7: Control bit 1 is the access enable. It is read/write and is shown on `dom_acc_o`. While it is 0 (value before the write), writes to control bits 4, 3, 2 and 0 are ignored, those bits read as 0, and status bit 0 reads as 0.
- R8: Status bits 4, 5 and 6 show `pwr_flags_i[0]`, `[1]` and `[2]` (power-on, brown-out, power status) whatever the access enable is. The other status bits read as 0.
- R9: All control bits are 0 after the domain power reset (`bkup_por_n` low). A main reset (`main_rst_n` low) clears only the access enable and leaves bits 4, 3 and 2 as they were.
- R10: Status bit 0 (oscillator ready) equals `osc_rdy_i` delayed by two clock edges, ANDed with the oscillator enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| main_rst_n | input | 1 | Main reset, active low, asynchronous |
| bkup_por_n | input | 1 | Backup-domain power reset, active low, asynchronous |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| addr | input | ADDR_W | Register address (control = 0, status = 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| osc_rdy_i | input | 1 | Asynchronous ready flag from the oscillator |
| pwr_flags_i | input | 3 | Power-on, brown-out and power status flags |
| osc_en_o | output | 1 | Oscillator enable |
| mon_en_o | output | 1 | Oscillator fault-monitor enable |
| clk_sel_o | output | 1 | Counter clock select (0 = 1 Hz, 1 = 1.024 kHz) |
| dom_rst_o | output | 1 | One-cycle domain reset pulse |
| dom_acc_o | output | 1 | Domain access enable |

## Verification
The assertions check on every cycle the properties that hold locally in time:
- the enables never drop without a domain reset event;
- the clock select stays put while the oscillator runs;
- nothing in the domain moves while access is closed;
- the reset pulse always comes with cleared settings;
- the ready flag never shows while the oscillator is off;
- the reserved read bits stay zero.

Only the bench scenarios can show the behaviours that depend on the exact write value or on reset sequencing:
- which write patterns are reset requests and which are blocked;
- the two-edge ready latency;
- the survival of the domain settings across a main reset;
- the full clear on domain power loss.

// File: rtl/bkc_pkg.sv
package bkc_pkg;

  // Control field positions (decoded by the domain)
  localparam int unsigned B_RST = 0;
  localparam int unsigned B_ACC = 1;
  localparam int unsigned B_MON = 2;
  localparam int unsigned B_OSC = 3;
  localparam int unsigned B_SEL = 4;

  // Status field positions
  localparam int unsigned S_RDY = 0;
  localparam int unsigned S_FLG = 4;

  localparam int unsigned DW     = 8;
  localparam int unsigned FLAG_W = 3;

  typedef struct packed {
    logic sel;
    logic osc;
    logic mon;
  } dom_bits_t;

  // A reset request counts only when no enable is set by the same write
  function automatic logic reset_allowed(input logic [DW-1:0] wd);
    return wd[B_RST] & ~wd[B_OSC] & ~wd[B_MON];
  endfunction

  // Next domain state for an accepted control write
  function automatic dom_bits_t dom_next(input dom_bits_t cur, input logic [DW-1:0] wd);
    dom_bits_t n;
    n.osc = cur.osc | wd[B_OSC];
    n.mon = cur.mon | wd[B_MON];
    n.sel = cur.osc ? cur.sel : wd[B_SEL];
    return n;
  endfunction

  function automatic logic [DW-1:0] ctrl_image(input dom_bits_t d, input logic acc);
    logic [DW-1:0] v;
    v = '0;
    v[B_ACC] = acc;
    v[B_SEL] = acc & d.sel;
    v[B_OSC] = acc & d.osc;
    v[B_MON] = acc & d.mon;
    return v;
  endfunction

  function automatic logic [DW-1:0] stat_image(input logic rdy, input logic acc,
                                              input logic [FLAG_W-1:0] flg);
    logic [DW-1:0] v;
    v = '0;
    v[S_RDY] = rdy & acc;
    v[S_FLG +: FLAG_W] = flg;
    return v;
  endfunction

endpackage

// File: rtl/bkc_sync.sv
module bkc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bkc_access.sv
module bkc_access (
  input  logic clk,
  input  logic main_rst_n,
  input  logic wr_ctrl,
  input  logic acc_wbit,
  output logic acc_en
);
  logic acc_q;

  always_ff @(posedge clk or negedge main_rst_n) begin
    if (!main_rst_n)  acc_q <= 1'b0;
    else if (wr_ctrl) acc_q <= acc_wbit;
  end

  assign acc_en = acc_q;
endmodule

// File: rtl/bkc_dom_bits.sv
module bkc_dom_bits
  import bkc_pkg::*;
(
  input  logic          clk,
  input  logic          por_n,
  input  logic          main_rst_n,
  input  logic          acc_en,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  output dom_bits_t     bits_q,
  output logic          dom_rst_evt,
  output logic          dom_upd
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:B_SEL+1], wdata[B_ACC]};

  assign dom_upd     = wr_ctrl & acc_en;
  assign dom_rst_evt = dom_upd & reset_allowed(wdata);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            bits_q <= '0;
    else if (dom_rst_evt)  bits_q <= '0;
    else if (dom_upd)      bits_q <= dom_next(bits_q, wdata);
  end

  // R2
  osc_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !main_rst_n)
    (bits_q.osc && !dom_rst_evt) |=> bits_q.osc);
  // R3
  mon_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !main_rst_n)
    (bits_q.mon && !dom_rst_evt) |=> bits_q.mon);
  // R4
  sel_lock_chk: assert property (@(posedge clk) disable iff (!por_n || !main_rst_n)
    (bits_q.osc && !dom_rst_evt) |=> $stable(bits_q.sel));
  // R7
  acc_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !main_rst_n)
    !acc_en |=> $stable(bits_q));
  // R5
  rst_clear_chk: assert property (@(posedge clk) disable iff (!por_n || !main_rst_n)
    dom_rst_evt |=> (bits_q == '0));
endmodule

// File: rtl/bkc_rdmux.sv
module bkc_rdmux
  import bkc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0,
  parameter int unsigned STAT_ADDR = 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  dom_bits_t         bits,
  input  logic              acc,
  input  logic              rdy,
  input  logic [FLAG_W-1:0] flags,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(CTRL_ADDR))      rdata = ctrl_image(bits, acc);
      else if (addr == ADDR_W'(STAT_ADDR)) rdata = stat_image(rdy, acc, flags);
    end
  end
endmodule

// File: rtl/bkup_ctl_reg.sv
module bkup_ctl_reg
  import bkc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned STAT_ADDR   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              main_rst_n,
  input  logic              bkup_por_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              osc_rdy_i,
  input  logic [2:0]        pwr_flags_i,
  output logic              osc_en_o,
  output logic              mon_en_o,
  output logic              clk_sel_o,
  output logic              dom_rst_o,
  output logic              dom_acc_o
);
  logic      wr_ctrl;
  logic      acc_en;
  dom_bits_t bits_q;
  logic      dom_rst_evt;
  logic      dom_upd;
  logic      rdy_sync;
  logic      rdy_flag;
  logic      rst_pulse_q;

  assign wr_ctrl = wr_en & (addr == ADDR_W'(CTRL_ADDR));

  bkc_access u_acc (
    .clk        (clk),
    .main_rst_n (main_rst_n),
    .wr_ctrl    (wr_ctrl),
    .acc_wbit   (wdata[B_ACC]),
    .acc_en     (acc_en)
  );

  bkc_dom_bits u_dom (
    .clk         (clk),
    .por_n       (bkup_por_n),
    .main_rst_n  (main_rst_n),
    .acc_en      (acc_en),
    .wr_ctrl     (wr_ctrl),
    .wdata       (wdata),
    .bits_q      (bits_q),
    .dom_rst_evt (dom_rst_evt),
    .dom_upd     (dom_upd)
  );

  bkc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (bkup_por_n),
    .d     (osc_rdy_i),
    .q     (rdy_sync)
  );

  // Ready is only meaningful while the oscillator is enabled
  assign rdy_flag = rdy_sync & bits_q.osc;

  always_ff @(posedge clk or negedge bkup_por_n) begin
    if (!bkup_por_n) rst_pulse_q <= 1'b0;
    else             rst_pulse_q <= dom_rst_evt;
  end

  bkc_rdmux #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_rd (
    .rd_en (rd_en),
    .addr  (addr),
    .bits  (bits_q),
    .acc   (acc_en),
    .rdy   (rdy_flag),
    .flags (pwr_flags_i),
    .rdata (rdata)
  );

  assign osc_en_o  = bits_q.osc;
  assign mon_en_o  = bits_q.mon;
  assign clk_sel_o = bits_q.sel;
  assign dom_rst_o = rst_pulse_q;
  assign dom_acc_o = acc_en;

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!bkup_por_n || !main_rst_n)
    rdata[7:5] == 3'b000);
  // R5
  pulse_clear_chk: assert property (@(posedge clk) disable iff (!bkup_por_n || !main_rst_n)
    dom_rst_o |-> (!osc_en_o && !mon_en_o && !clk_sel_o));
  // R10
  rdy_gate_chk: assert property (@(posedge clk) disable iff (!bkup_por_n || !main_rst_n)
    !osc_en_o |-> !rdy_flag);
  // R7
  closed_write_chk: assert property (@(posedge clk) disable iff (!bkup_por_n || !main_rst_n)
    (wr_ctrl && !acc_en) |=> !dom_rst_o);
endmodule

// File: tb/bkup_ctl_reg_test.sv
module bkup_ctl_reg_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       main_rst_n = 1'b0;
  logic       bkup_por_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       osc_rdy_i = 1'b0;
  logic [2:0] pwr_flags_i = 3'b000;
  logic       osc_en_o, mon_en_o, clk_sel_o, dom_rst_o, dom_acc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the register
  logic m_acc = 1'b0, m_osc = 1'b0, m_mon = 1'b0, m_sel = 1'b0;
  logic m_pulse = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bkup_ctl_reg uut (
    .clk(clk), .main_rst_n(main_rst_n), .bkup_por_n(bkup_por_n),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .osc_rdy_i(osc_rdy_i), .pwr_flags_i(pwr_flags_i),
    .osc_en_o(osc_en_o), .mon_en_o(mon_en_o), .clk_sel_o(clk_sel_o),
    .dom_rst_o(dom_rst_o), .dom_acc_o(dom_acc_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_ctrl();
    return m_acc ? {3'b000, m_sel, m_osc, m_mon, 1'b1, 1'b0} : 8'h00;
  endfunction

  task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    #1;
    v = rdata;
    rd_en = 1'b0; addr = 2'd0;
  endtask

  task automatic check_state(input string req);
    logic [7:0] v;
    check(req, {3'b0, dom_acc_o, osc_en_o, mon_en_o, clk_sel_o, dom_rst_o},
          {3'b0, m_acc, m_osc, m_mon, m_sel, m_pulse});
    read_reg(2'd0, v);
    check(req, v, exp_ctrl());
  endtask

  // write at the next edge; afterwards it sits at the following negedge
  task automatic write_ctrl(input logic [7:0] d, input string req);
    logic rst;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wdata = d;
    @(posedge clk);
    m_pulse = 1'b0;
    if (m_acc) begin
      rst = d[0] & ~d[3] & ~d[2];
      if (rst) begin
        m_osc = 1'b0; m_mon = 1'b0; m_sel = 1'b0; m_pulse = 1'b1;
      end else begin
        if (!m_osc) m_sel = d[4];
        m_osc = m_osc | d[3];
        m_mon = m_mon | d[2];
      end
    end
    m_acc = d[1];
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
    check_state(req);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check_state("R9 after power-up");
    read_reg(2'd1, v);
    check("R9 status after power-up", v, 8'h00);
  endtask

  task automatic t_closed();
    write_ctrl(8'h1D, "R7 closed write ignored");
    write_ctrl(8'h02, "R7 open access");
  endtask

  task automatic t_reserved_sel();
    write_ctrl(8'hF2, "R1 reserved ignored, R4 sel=1");
    check("R4 1.024 kHz selected", {7'b0, clk_sel_o}, 8'h01);
    write_ctrl(8'h02, "R4 sel back to 1 Hz");
    write_ctrl(8'hE2, "R1 reserved bits read zero");
  endtask

  task automatic t_osc();
    write_ctrl(8'h1A, "R2 osc set, R4 sel written with it");
    write_ctrl(8'h02, "R4 sel locked / R2 zero no effect");
    check("R2 osc still on", {7'b0, osc_en_o}, 8'h01);
    write_ctrl(8'h0A, "R4 clear of sel ignored while osc on");
    check("R4 sel still 1", {7'b0, clk_sel_o}, 8'h01);
  endtask

  task automatic t_ready();
    logic [7:0] v;
    @(negedge clk);
    osc_rdy_i = 1'b1;
    read_reg(2'd1, v);
    check("R10 ready after 0 edges", v, 8'h00);
    @(negedge clk);
    read_reg(2'd1, v);
    check("R10 ready after 1 edge", v, 8'h00);
    @(negedge clk);
    read_reg(2'd1, v);
    check("R10 ready after 2 edges", v, 8'h01);
  endtask

  task automatic t_mon();
    write_ctrl(8'h06, "R3 monitor set");
    write_ctrl(8'h02, "R3 zero has no effect");
    check("R3 monitor still on", {7'b0, mon_en_o}, 8'h01);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    pwr_flags_i = 3'b101;
    read_reg(2'd1, v);
    check("R8 flags with access, R10 ready", v, 8'h51);
    write_ctrl(8'h00, "R7 close access");
    read_reg(2'd1, v);
    check("R8 flags visible, R7 ready hidden", v, 8'h50);
    pwr_flags_i = 3'b010;
    read_reg(2'd1, v);
    check("R8 flag pattern 2", v, 8'h20);
    write_ctrl(8'h01, "R7 reset request blocked while closed");
    write_ctrl(8'h02, "R7 reopen");
  endtask

  task automatic t_main_reset();
    @(negedge clk); main_rst_n = 1'b0;
    @(negedge clk); main_rst_n = 1'b1;
    m_acc = 1'b0;
    check_state("R9 main reset keeps domain bits");
    write_ctrl(8'h02, "R9 bits visible after main reset");
  endtask

  task automatic t_blocked_reset();
    write_ctrl(8'h0B, "R6 reset with osc bit blocked");
    write_ctrl(8'h07, "R6 reset with mon bit blocked");
  endtask

  task automatic t_dom_reset();
    logic [7:0] v;
    write_ctrl(8'h03, "R5 domain reset");
    @(negedge clk);
    m_pulse = 1'b0;
    check_state("R5 pulse is one cycle");
    read_reg(2'd1, v);
    check("R5 ready flag cleared", v[0], 1'b0);
    write_ctrl(8'h12, "R5 sel writable again");
  endtask

  task automatic t_por();
    write_ctrl(8'h0E, "R9 set before power loss");
    @(negedge clk); bkup_por_n = 1'b0; main_rst_n = 1'b0;
    @(negedge clk); bkup_por_n = 1'b1; main_rst_n = 1'b1;
    m_acc = 1'b0; m_osc = 1'b0; m_mon = 1'b0; m_sel = 1'b0; m_pulse = 1'b0;
    check_state("R9 power reset clears all");
    write_ctrl(8'h02, "R9 cleared bits after reopen");
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    bkup_por_n = 1'b1;
    main_rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_closed();
    t_reserved_sel();
    t_osc();
    t_ready();
    t_mon();
    t_flags();
    t_main_reset();
    t_blocked_reset();
    t_dom_reset();
    t_por();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule